// File: doc/BRIEF.md
# UART Interrupt Identification Prioritizer

This block holds the interrupt enable and interrupt identification state of a 16550-style serial port and drives its level interrupt line. The surrounding port logic feeds it the line status byte, the modem delta flags and the strobes for register accesses. Four interrupt sources are considered, each gated by its own enable bit. The block reports the most urgent enabled source as a 4-bit identification code and raises the interrupt while any enabled source is active.

The block also keeps the "transmit holding register empty" pending flag. A write to the enable register arms the flag when the transmitter is empty. A write to the transmit holding register clears it. A read of the identification register that returns the transmit-empty code also clears it. The upper nibble of the identification register is loaded only through its own write strobe, for example by FIFO control logic. Source updates never touch it.

The identification register and the interrupt output are registered. Both reflect the enable register, the pending flag and the status inputs as they stood in the previous cycle.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset, `ier_o` is 0x0, `iir_o` is 0x01 and `irq_o` is 0.
- R2: A write to the enable register stores bits [3:0] of `ier_wdata_i` and ignores bits [7:4]. `ier_o` shows the stored value after the write edge and holds it until the next write.
- R3: While the enable register is nonzero, the identification low nibble is the most urgent active enabled source. The codes are, most urgent first: line status 0x6, received data 0x4, transmit empty 0x2, modem status 0x0. The code 0x1 means no source is active.
- R4: The line status source is active only when enable bit 2 is set and any of `lsr_i` bits 1..4 is set. `lsr_i` bits 0, 5, 6 and 7 do not trigger it.
- R5: The received data source is active only when enable bit 0 is set and `lsr_i` bit 0 is set.
- R6: The transmit-empty source needs enable bit 1 and the pending flag. The flag is set by an enable write while `lsr_i` bit 5 is high. It is cleared by `thr_we_i`, or by `iir_re_i` while `iir_o[3:0]` is 0x2. A set in the same cycle as a clear wins.
- R7: The modem status source is active only when enable bit 3 is set and any bit of `msr_delta_i` is set.
- R8: While the enable register is zero, `irq_o` is driven low and `iir_o[3:0]` keeps its previous value.
- R9: `iir_o[7:4]` changes only on `iir_hi_we_i`, which loads `iir_hi_i`. Source updates preserve it.
- R10: `irq_o` is high exactly when the enable register was nonzero and the selected code was not 0x1, one cycle after the inputs it reflects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ier_we_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| thr_we_i | input | 1 | Transmit holding register write strobe |
| iir_re_i | input | 1 | Identification register read strobe |
| iir_hi_we_i | input | 1 | Identification upper nibble write strobe |
| iir_hi_i | input | 4 | Identification upper nibble data |
| lsr_i | input | 8 | Line status byte |
| msr_delta_i | input | 4 | Modem status delta flags |
| ier_o | output | 4 | Enable register value |
| iir_o | output | 8 | Identification register value |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest state to reach is a zero enable register combined with a stale, nonzero identification code. The bench first enables only the transmit-empty source with `lsr_i` bit 5 high, so the code becomes 0x2. It then writes zero to the enable register and checks that the interrupt drops while 0x2 stays visible. Read-clear is exercised by pulsing `iir_re_i` both while the code is 0x2 and while it is not. The bench also runs a long random mix of all strobes, including same-cycle set and clear of the pending flag. That mix is compared every cycle against a behavioural model.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned IER_W  = 4;
  localparam int unsigned ID_W   = 4;
  localparam int unsigned N_SRC  = 4;

  // identification codes (low nibble)
  localparam logic [ID_W-1:0] ID_NONE   = 4'h1;
  localparam logic [ID_W-1:0] ID_LINE   = 4'h6;
  localparam logic [ID_W-1:0] ID_RXDATA = 4'h4;
  localparam logic [ID_W-1:0] ID_THRE   = 4'h2;
  localparam logic [ID_W-1:0] ID_MODEM  = 4'h0;

  // enable bit positions
  localparam int unsigned EN_RX    = 0;
  localparam int unsigned EN_THRE  = 1;
  localparam int unsigned EN_LINE  = 2;
  localparam int unsigned EN_MODEM = 3;

  // line status bits
  localparam int unsigned LSR_DR   = 0;
  localparam int unsigned LSR_THRE = 5;
  localparam logic [7:0]  LSR_ERR_MASK = 8'h1E;

  // source order = priority order, index 0 most urgent
  typedef enum logic [1:0] {
    SRC_LINE  = 2'd0,
    SRC_RX    = 2'd1,
    SRC_THRE  = 2'd2,
    SRC_MODEM = 2'd3
  } src_e;

  function automatic logic [ID_W-1:0] src_code(input int unsigned idx);
    case (idx)
      0:       return ID_LINE;
      1:       return ID_RXDATA;
      2:       return ID_THRE;
      default: return ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_ier.sv
module uart_irq_ier
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              thr_we_i,
  input  logic              iir_re_i,
  input  logic [ID_W-1:0]   cur_id_i,
  input  logic              lsr_thre_i,
  output logic [IER_W-1:0]  ier_o,
  output logic              thr_pend_o
);
  logic [IER_W-1:0] ier_q;
  logic             pend_q;
  logic             pend_set, pend_clr;
  logic             unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:IER_W];

  assign pend_set = we_i && lsr_thre_i;
  assign pend_clr = thr_we_i || (iir_re_i && (cur_id_i == ID_THRE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q <= '0;
    end else if (we_i) begin
      ier_q <= wdata_i[IER_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (pend_set) begin
      pend_q <= 1'b1;
    end else if (pend_clr) begin
      pend_q <= 1'b0;
    end
  end

  assign ier_o      = ier_q;
  assign thr_pend_o = pend_q;

  p_ier_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ier_o == $past(wdata_i[IER_W-1:0]));
  p_ier_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ier_o));
  p_pend_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lsr_thre_i) |=> thr_pend_o);
  p_pend_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_we_i && !(we_i && lsr_thre_i)) |=> !thr_pend_o);
endmodule

// File: rtl/uart_irq_sel.sv
module uart_irq_sel
  import uart_irq_pkg::*;
#(
  parameter int unsigned LSR_W = 8,
  parameter int unsigned MSR_W = 4
) (
  input  logic [IER_W-1:0] ier_i,
  input  logic [LSR_W-1:0] lsr_i,
  input  logic             thr_pend_i,
  input  logic [MSR_W-1:0] msr_delta_i,
  output logic [ID_W-1:0]  id_o,
  output logic             any_o
);
  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] gnt;

  assign req[SRC_LINE]  = ier_i[EN_LINE]  && |(lsr_i & LSR_W'(LSR_ERR_MASK));
  assign req[SRC_RX]    = ier_i[EN_RX]    && lsr_i[LSR_DR];
  assign req[SRC_THRE]  = ier_i[EN_THRE]  && thr_pend_i;
  assign req[SRC_MODEM] = ier_i[EN_MODEM] && |msr_delta_i;

  // fixed priority: lower index wins
  for (genvar g = 0; g < N_SRC; g++) begin : g_pri
    if (g == 0) begin : g_top
      assign gnt[g] = req[g];
    end else begin : g_rest
      assign gnt[g] = req[g] && !(|req[g-1:0]);
    end
  end

  always_comb begin
    id_o = ID_NONE;
    for (int i = 0; i < N_SRC; i++) begin
      if (gnt[i]) id_o = src_code(i);
    end
  end

  assign any_o = |req;

  always_comb begin
    p_gnt_onehot_r3: assert ($onehot0(gnt));
  end
endmodule

// File: rtl/uart_irq_iir.sv
module uart_irq_iir
  import uart_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IER_W-1:0] ier_i,
  input  logic [ID_W-1:0]  sel_id_i,
  input  logic             sel_any_i,
  input  logic             hi_we_i,
  input  logic [3:0]       hi_i,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic [3:0] hi_q;
  logic [3:0] lo_q;
  logic       irq_q;
  logic       ier_on;

  assign ier_on = |ier_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
    end else if (hi_we_i) begin
      hi_q <= hi_i;
    end
  end

  // zero enable register: hold identification, force line low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= ID_NONE;
      irq_q <= 1'b0;
    end else if (!ier_on) begin
      irq_q <= 1'b0;
    end else begin
      lo_q  <= sel_id_i;
      irq_q <= sel_any_i;
    end
  end

  assign iir_o = {hi_q, lo_q};
  assign irq_o = irq_q;

  p_zero_ier_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_on |=> !irq_o);
  p_zero_ier_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ier_on |=> $stable(iir_o[3:0]));
  p_hi_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_we_i |=> $stable(iir_o[7:4]));
  p_irq_id_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> iir_o[3:0] != ID_NONE);
  p_irq_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_on && sel_id_i != ID_NONE) |=> irq_o);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MSR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ier_we_i,
  input  logic [DATA_W-1:0] ier_wdata_i,
  input  logic              thr_we_i,
  input  logic              iir_re_i,
  input  logic              iir_hi_we_i,
  input  logic [3:0]        iir_hi_i,
  input  logic [DATA_W-1:0] lsr_i,
  input  logic [MSR_W-1:0]  msr_delta_i,
  output logic [IER_W-1:0]  ier_o,
  output logic [7:0]        iir_o,
  output logic              irq_o
);
  logic [IER_W-1:0] ier;
  logic             thr_pend;
  logic [ID_W-1:0]  sel_id;
  logic             sel_any;

  uart_irq_ier #(.DATA_W(DATA_W)) u_ier (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ier_we_i),
    .wdata_i    (ier_wdata_i),
    .thr_we_i   (thr_we_i),
    .iir_re_i   (iir_re_i),
    .cur_id_i   (iir_o[3:0]),
    .lsr_thre_i (lsr_i[LSR_THRE]),
    .ier_o      (ier),
    .thr_pend_o (thr_pend)
  );

  uart_irq_sel #(.LSR_W(DATA_W), .MSR_W(MSR_W)) u_sel (
    .ier_i       (ier),
    .lsr_i       (lsr_i),
    .thr_pend_i  (thr_pend),
    .msr_delta_i (msr_delta_i),
    .id_o        (sel_id),
    .any_o       (sel_any)
  );

  uart_irq_iir u_iir (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ier_i     (ier),
    .sel_id_i  (sel_id),
    .sel_any_i (sel_any),
    .hi_we_i   (iir_hi_we_i),
    .hi_i      (iir_hi_i),
    .iir_o     (iir_o),
    .irq_o     (irq_o)
  );

  assign ier_o = ier;
endmodule

// File: tb/tb_uart_irq_prio.sv
`timescale 1ns/1ps
module tb_uart_irq_prio;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ier_we = 1'b0;
  logic [7:0] ier_wdata = '0;
  logic       thr_we = 1'b0;
  logic       iir_re = 1'b0;
  logic       hi_we = 1'b0;
  logic [3:0] hi_d = '0;
  logic [7:0] lsr = '0;
  logic [3:0] msr = '0;
  logic [3:0] ier_o;
  logic [7:0] iir_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [3:0] m_ier;
  logic       m_pend;
  logic [7:0] m_iir;
  logic       m_irq;

  always #5 clk = ~clk;

  uart_irq_prio dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ier_we_i(ier_we), .ier_wdata_i(ier_wdata),
    .thr_we_i(thr_we), .iir_re_i(iir_re),
    .iir_hi_we_i(hi_we), .iir_hi_i(hi_d),
    .lsr_i(lsr), .msr_delta_i(msr),
    .ier_o(ier_o), .iir_o(iir_o), .irq_o(irq_o)
  );

  function automatic logic [3:0] ref_code(logic [3:0] en, logic [7:0] ls,
                                          logic pend, logic [3:0] md);
    if (en[2] && (ls[1] || ls[2] || ls[3] || ls[4])) return 4'h6;
    if (en[0] && ls[0]) return 4'h4;
    if (en[1] && pend) return 4'h2;
    if (en[3] && md != 0) return 4'h0;
    return 4'h1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ier = 0; m_pend = 0; m_iir = 8'h01; m_irq = 0;
    end else begin
      logic [3:0] code;
      logic [3:0] o_ier;
      logic       o_pend;
      logic [7:0] o_iir;
      o_ier = m_ier; o_pend = m_pend; o_iir = m_iir;
      code = ref_code(o_ier, lsr, o_pend, msr);
      if (hi_we) m_iir[7:4] = hi_d;
      if (o_ier != 0) begin
        m_iir[3:0] = code;
        m_irq = (code != 4'h1);
      end else begin
        m_irq = 0;
      end
      if (ier_we && lsr[5]) m_pend = 1;
      else if (thr_we || (iir_re && o_iir[3:0] == 4'h2)) m_pend = 0;
      if (ier_we) m_ier = ier_wdata[3:0];
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // advance one cycle; compare at the falling edge
  task automatic step();
    @(negedge clk);
    chk("R2 ier", {4'h0, ier_o}, {4'h0, m_ier});
    chk("R3 iir", iir_o, m_iir);
    chk("R10 irq", {7'h0, irq_o}, {7'h0, m_irq});
  endtask

  task automatic settle();
    step(); step();
  endtask

  task automatic wr_ier(logic [7:0] v);
    ier_we = 1; ier_wdata = v; step(); ier_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset iir", iir_o, 8'h01);
    chk("R1 reset irq", {7'h0, irq_o}, 8'h00);
    chk("R1 reset ier", {4'h0, ier_o}, 8'h00);
    rst_n = 1;
    step();

    // R2 upper bits ignored; R6 set on write with lsr bit5
    lsr = 8'h60;
    wr_ier(8'hF2);
    chk("R2 low nibble", {4'h0, ier_o}, 8'h02);
    settle();
    chk("R6 thre code", {4'h0, iir_o[3:0]}, 8'h02);
    chk("R6 thre irq", {7'h0, irq_o}, 8'h01);

    // R6 read while code 0x2 clears
    lsr = 8'h00;
    iir_re = 1; step(); iir_re = 0;
    settle();
    chk("R6 read clear", {4'h0, iir_o[3:0]}, 8'h01);
    chk("R6 read clear irq", {7'h0, irq_o}, 8'h00);

    // R5 rx data
    wr_ier(8'h01);
    lsr = 8'h01; settle();
    chk("R5 rx code", {4'h0, iir_o[3:0]}, 8'h04);
    lsr = 8'h00; settle();
    chk("R5 no dr", {4'h0, iir_o[3:0]}, 8'h01);

    // R4 line status beats rx (R3)
    wr_ier(8'h07);
    lsr = 8'h03; settle();
    chk("R4 overrun wins R3", {4'h0, iir_o[3:0]}, 8'h06);
    lsr = 8'h11; settle();
    chk("R4 break", {4'h0, iir_o[3:0]}, 8'h06);
    lsr = 8'hC1; settle();
    chk("R4 bits6/7 ignored", {4'h0, iir_o[3:0]}, 8'h04);

    // R7 modem lowest priority
    lsr = 8'h00;
    wr_ier(8'h08);
    msr = 4'h4; settle();
    chk("R7 modem code", {4'h0, iir_o[3:0]}, 8'h00);
    chk("R7 modem irq", {7'h0, irq_o}, 8'h01);
    wr_ier(8'h0F); lsr = 8'h01; settle();
    chk("R3 rx over modem", {4'h0, iir_o[3:0]}, 8'h04);
    lsr = 8'h00; msr = 4'h0; settle();
    chk("R7 no delta", {4'h0, iir_o[3:0]}, 8'h01);

    // R8 zero enable holds stale code
    lsr = 8'h20; wr_ier(8'h02); lsr = 8'h00; settle();
    chk("R8 pre code", {4'h0, iir_o[3:0]}, 8'h02);
    wr_ier(8'h00); settle();
    chk("R8 irq low", {7'h0, irq_o}, 8'h00);
    chk("R8 code held", {4'h0, iir_o[3:0]}, 8'h02);
    lsr = 8'h1F; msr = 4'hF; settle();
    chk("R8 sources ignored", {7'h0, irq_o}, 8'h00);
    lsr = 8'h00; msr = 4'h0;

    // R9 upper nibble
    hi_we = 1; hi_d = 4'hC; step(); hi_we = 0;
    wr_ier(8'h02); settle();
    chk("R9 hi kept", {4'h0, iir_o[7:4]}, 8'h0C);

    // R6 thr write clears
    thr_we = 1; step(); thr_we = 0; settle();
    chk("R6 thr write clear", {4'h0, iir_o[3:0]}, 8'h01);
    chk("R9 hi kept 2", {4'h0, iir_o[7:4]}, 8'h0C);

    // R6 read while not 0x2 leaves flag
    lsr = 8'h21; wr_ier(8'h03); settle();
    iir_re = 1; step(); iir_re = 0; lsr = 8'h00; settle();
    chk("R6 read other keeps", {4'h0, iir_o[3:0]}, 8'h02);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      ier_we    = ($urandom % 8) == 0;
      ier_wdata = 8'($urandom);
      thr_we    = ($urandom % 8) == 0;
      iir_re    = ($urandom % 4) == 0;
      hi_we     = ($urandom % 16) == 0;
      hi_d      = 4'($urandom);
      lsr       = 8'($urandom) & (($urandom % 2) ? 8'hE1 : 8'hFF);
      msr       = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      step();
    end
    ier_we = 0; thr_we = 0; iir_re = 0; hi_we = 0;
    step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule